// File: doc/BRIEF.md
# Multiphase Dynamic Precharge-Evaluate Sequencer

This block drives the control strobes for a cascade of dynamic logic stages. Each stage gets one precharge strobe and one evaluate strobe. A stage works through a fixed sequence of phase slots: first a precharge slot, then an evaluate slot, then one or two hold slots in which both strobes are low and the stage's outputs stay latched on the wires. Each stage runs one slot behind the stage before it. As a result, stage k evaluates in the same slot in which stage k+1 precharges.

A static mode input picks one of two schemes. The three-phase scheme has one hold slot per stage. The four-phase scheme adds a second hold slot, so a stage is precharged again only after the stage two positions downstream has finished evaluating. This keeps the precharge disturbance away from a value that is still being consumed. A phase-advance enable sets the pace: the slot index moves forward only on cycles where the enable is high. The current slot index is an output.

Top module: `mps_sequencer`

## Requirements
- R1: While reset is high, and on the cycle after it is released, every pre and eva output is low and the slot index output is 0.
- R2: After reset, the first cycle with the advance enable high starts the sequence at slot 0. One cycle later, stage 0 shows pre=1 and eva=0. The selected scheme is taken from the mode input on that cycle (0 = three slots, 1 = four slots).
- R3: Let N be 3 or 4 and let s be the current slot. Stage k (counted from 0) uses local phase p = (s - k) mod N. It has pre=1, eva=0 when p=0, and pre=0, eva=1 when p=1. For every other p, both strobes are low.
- R4: The slot index output counts 0,1,...,N-1 and then returns to 0. It moves one step on each cycle with the advance enable high.
- R5: On a cycle with the advance enable low, no output changes on the next cycle.
- R6: A change of the mode input takes effect only when the slot index wraps from N-1 to 0. At all other points the running scheme is kept.
- R7: No two adjacent stages are in their evaluate slot at the same time, and no stage has pre and eva high together.
- R8: In four-slot mode, stage k+4 carries the same strobes as stage k. Stage k is precharged in the slot right after the slot in which stage k+2 evaluates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Phase-advance enable |
| mode_4ph | input | 1 | Scheme select: 0 three-slot, 1 four-slot |
| pre | output | NUM_STAGES | Per-stage precharge strobes |
| eva | output | NUM_STAGES | Per-stage evaluate strobes |
| phase_idx | output | 2 | Current slot index |

## Verification
The bench targets four kinds of error:
- Mode changes in the middle of a cycle. A design that switches mode at once would break the rotation of the strobes and show a stage evaluating twice or precharging straight after it evaluates.
- Stalls of the advance enable, including long runs with the enable low. A design that advanced without the enable, or glitched while stalled, would fail the next cycle's comparison.
- Stages at or beyond N, where the rotation must wrap modulo N. Getting that modulus wrong would put two adjacent stages in their evaluate slot together.
- A reset in the middle of a run, and the first advance after it. A design that left stale strobes or started at a slot other than 0 would be caught there.

// File: rtl/mps_pkg.sv
package mps_pkg;

    localparam int unsigned MAX_SLOTS = 4;
    localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS);

    typedef enum logic {
        SCHEME_3 = 1'b0,
        SCHEME_4 = 1'b1
    } scheme_e;

    typedef enum logic [1:0] {
        PH_PRE   = 2'd0,
        PH_EVA   = 2'd1,
        PH_HOLDA = 2'd2,
        PH_HOLDB = 2'd3
    } stage_phase_e;

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] slot;
        scheme_e           scheme;
    } seq_state_t;

    function automatic int unsigned slots_of(scheme_e s);
        return (s == SCHEME_4) ? 4 : 3;
    endfunction

    function automatic stage_phase_e local_phase(logic [SLOT_W-1:0] slot,
                                                 int unsigned stage,
                                                 scheme_e s);
        int unsigned n;
        int unsigned p;
        n = slots_of(s);
        p = (int'(slot) + n - (stage % n)) % n;
        return stage_phase_e'(p[1:0]);
    endfunction

endpackage

// File: rtl/mps_slot_counter.sv
module mps_slot_counter
    import mps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  scheme_e    mode_sel,
    output seq_state_t st
);

    seq_state_t nxt;
    logic       at_last;

    always_comb begin
        at_last = (int'(st.slot) == slots_of(st.scheme) - 1);
        nxt = st;
        if (adv) begin
            if (!st.run) begin
                nxt.run    = 1'b1;
                nxt.slot   = '0;
                nxt.scheme = mode_sel;
            end else if (at_last) begin
                nxt.slot   = '0;
                nxt.scheme = mode_sel;
            end else begin
                nxt.slot = st.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.run    <= 1'b0;
            st.slot   <= '0;
            st.scheme <= SCHEME_3;
        end else begin
            st <= nxt;
        end
    end

    // R4: slot stays inside the running cycle length
    p_slot_range_r4: assert property (@(posedge clk) disable iff (rst)
        int'(st.slot) < slots_of(st.scheme));

    // R4: wrap back to zero after the last slot
    p_slot_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (st.run && adv && at_last) |=> (st.slot == '0));

    // R6: scheme only changes at a wrap or at start
    p_scheme_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st.run && !(adv && at_last)) |=> $stable(st.scheme));

endmodule

// File: rtl/mps_stage_strobe.sv
module mps_stage_strobe
    import mps_pkg::*;
#(
    parameter int unsigned STAGE_IDX = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t st,
    output logic       pre,
    output logic       eva
);

    stage_phase_e ph;

    always_comb begin
        ph  = local_phase(st.slot, STAGE_IDX, st.scheme);
        pre = st.run && (ph == PH_PRE);
        eva = st.run && (ph == PH_EVA);
    end

    // R7: one strobe at a time per stage
    p_excl_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !(pre && eva));

endmodule

// File: rtl/mps_sequencer.sv
module mps_sequencer
    import mps_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic                  mode_4ph,
    output logic [NUM_STAGES-1:0] pre,
    output logic [NUM_STAGES-1:0] eva,
    output logic [SLOT_W-1:0]     phase_idx
);

    seq_state_t st;
    scheme_e    mode_sel;

    assign mode_sel  = mode_4ph ? SCHEME_4 : SCHEME_3;
    assign phase_idx = st.slot;

    mps_slot_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .mode_sel (mode_sel),
        .st       (st)
    );

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        mps_stage_strobe #(.STAGE_IDX(k)) u_stg (
            .clk (clk),
            .rst (rst),
            .st  (st),
            .pre (pre[k]),
            .eva (eva[k])
        );
    end

    // R7: neighbours never evaluate together
    p_no_adj_eva_r7: assert property (@(posedge clk) disable iff (rst)
        (eva & (eva >> 1)) == '0);

    // R5: stalled cycle freezes every output
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(pre) && $stable(eva) && $stable(phase_idx)));

    // R3: a stage that evaluates moves to hold, never straight to precharge
    p_eva_then_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (eva[0] && adv && (st.scheme == mode_sel)) |=> !pre[0]);

    // R2: first advance starts at slot zero with stage 0 precharging
    p_start_slot0_r2: assert property (@(posedge clk) disable iff (rst)
        (!st.run && adv) |=> (phase_idx == '0 && pre[0] && !eva[0]));

endmodule

// File: tb/tb_mps_sequencer.sv
module tb_mps_sequencer;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          adv = 1'b0;
    logic          mode_4ph = 1'b0;
    logic [NS-1:0] pre;
    logic [NS-1:0] eva;
    logic [1:0]    phase_idx;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    bit m_run  = 0;
    int m_slot = 0;
    bit m_4ph  = 0;

    always #4 clk = ~clk;

    mps_sequencer #(.NUM_STAGES(NS)) dut (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .mode_4ph  (mode_4ph),
        .pre       (pre),
        .eva       (eva),
        .phase_idx (phase_idx)
    );

    function automatic logic [NS-1:0] exp_vec(int want);
        logic [NS-1:0] v = '0;
        int n = m_4ph ? 4 : 3;
        if (m_run)
            for (int k = 0; k < NS; k++)
                v[k] = (((m_slot + n - (k % n)) % n) == want);
        return v;
    endfunction

    task automatic chk(string tag, logic [NS-1:0] act, logic [NS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(bit r, bit a, bit md);
        string tag;
        bit started = 0;
        bit wrapped = 0;
        int n;
        rst = r; adv = a; mode_4ph = md;
        @(posedge clk);
        n = m_4ph ? 4 : 3;
        if (r) begin
            m_run = 0; m_slot = 0; m_4ph = 0;
        end else if (a) begin
            if (!m_run) begin
                m_run = 1; m_slot = 0; m_4ph = md; started = 1;
            end else if (m_slot == n - 1) begin
                m_slot = 0; m_4ph = md; wrapped = 1;
            end else begin
                m_slot++;
            end
        end
        @(negedge clk);
        if (r)            tag = "R1";
        else if (started) tag = "R2";
        else if (!a)      tag = "R5";
        else if (wrapped) tag = "R6";
        else              tag = "R3";
        chk({tag, " pre"}, pre, exp_vec(0));
        chk({tag, " eva"}, eva, exp_vec(1));
        chk("R4 idx", {{(NS-2){1'b0}}, phase_idx}, NS'(m_slot));
        chk("R7 adj eva", eva & (eva >> 1), '0);
        chk("R7 excl", pre & eva, '0);
        if (m_run && m_4ph) begin
            chk("R8 period eva", eva[NS-1:4], eva[3:0]);
            chk("R8 period pre", pre[NS-1:4], pre[3:0]);
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] lfsr = 8'hA5;
        bit md = 0;
        step(1, 0, 0);
        step(1, 1, 1);
        step(0, 0, 1);
        step(0, 0, 0);
        // R2: start in three-slot mode
        step(0, 1, 0);
        for (int i = 0; i < 7; i++) step(0, 1, 0);
        // R6: request four-slot in mid cycle
        for (int i = 0; i < 9; i++) step(0, 1, 1);
        for (int i = 0; i < 5; i++) step(0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (i % 23 == 0) md = ~md;
            step((i == 200), (lfsr[1:0] != 2'b00), md);
        end
        // R2: start in four-slot mode after reset
        step(1, 0, 1);
        step(0, 1, 1);
        for (int i = 0; i < 12; i++) step(0, 1, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule